// File: doc/BRIEF.md
# Eight-Read Replicated Operand Store

This block is a scalar operand memory for an arithmetic datapath that needs eight operands in every cycle. Eight identical copies of a 512-entry, 32-bit dual-port memory are kept side by side. Each read lane has a copy of its own, and every write is sent to all copies in the same cycle. The lanes therefore always agree, and eight independent reads complete together with one cycle of latency.

There are two write sources. The coprocessor datapath writes results back, and a host loads operands. They share the single write port through a fixed-priority selector. The coprocessor wins a collision. The host write is then dropped for that cycle, and `host_busy` tells the host to hold its request and present it again.

A read of an address that is written in the same cycle returns the value stored before that write, and it does so on every lane.

Top module: `opstore8`

## Requirements
- R1: Each of the eight read lanes returns the word stored at its own address, with that lane's 9-bit address taken from bits [9k+8:9k] of `rd_addr` and its data placed on bits [32k+31:32k] of `rd_data`. The data appears one clock cycle after the address is presented, and all lanes are independent of one another.
- R2: Every accepted write is applied to all eight copies, so lanes that read the same address in the same cycle return identical data.
- R3: When `core_we` and `host_we` are both high in a cycle, only the core write is stored. The host's target address keeps its previous contents.
- R4: `host_busy` is high in exactly those cycles in which `host_we` and `core_we` are both high. It is combinational and has no cycle of delay.
- R5: A host write made while `core_we` is low is stored at `host_waddr`.
- R6: A read of an address being written in the same cycle returns the old value on every lane (read-first).
- R7: While `rst_n` is low, and in the first cycle after reset ends, `rd_data` is all zeros. Reset does not clear the stored words.
- R8: A word written in cycle n is returned by any lane whose read address is presented in cycle n+1 or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_we | input | 1 | Coprocessor write enable; has priority |
| core_waddr | input | 9 | Coprocessor write address |
| core_wdata | input | 32 | Coprocessor write data |
| host_we | input | 1 | Host write enable |
| host_waddr | input | 9 | Host write address |
| host_wdata | input | 32 | Host write data |
| host_busy | output | 1 | Host write not accepted this cycle |
| rd_addr | input | 72 | Eight packed 9-bit read addresses; lane k is bits [9k+8:9k] |
| rd_data | output | 256 | Eight packed 32-bit read words; lane k is bits [32k+31:32k] |

## Verification
The bench reads the same address on all eight lanes to expose a copy that missed a broadcast write. If one bank's write enable or address were miswired, that lane alone would return stale data. It drives simultaneous core and host writes to different addresses. A selector that let the host win, or that wrote both, would corrupt the host's target word or lose the core result, and a wrongly derived busy flag would show up in that same cycle. Reads of the address being written check read-first ordering, which a write-first bank would break by returning the new word one cycle early. A final sweep over all 512 entries compares every lane with the bench's model after thousands of random mixed writes.

// File: rtl/opstore_pkg.sv
// Shared sizing for the replicated operand store.
// Assumes the power-of-two depth given by the address width.
package opstore_pkg;
    localparam int OS_LANES  = 8;
    localparam int OS_ADDR_W = 9;
    localparam int OS_DATA_W = 32;

    // Winning write request after arbitration
    typedef struct packed {
        logic                 en;
        logic [OS_ADDR_W-1:0] addr;
        logic [OS_DATA_W-1:0] data;
    } os_wreq_t;
endpackage

// File: rtl/opstore_bank.sv
// One copy of the operand storage: one write port and one registered read port.
// A read and a write to the same address in one cycle return the old word.
// Assumes that the stored words need no reset; only the read register is reset.
module opstore_bank #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the broadcast write
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Register the read word; the nonblocking update gives read-first order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/opstore_wsel.sv
// Fixed-priority write selector: a core write beats a host write.
// A host write that loses is dropped, and busy is raised so that the host retries.
module opstore_wsel #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_waddr,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_waddr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              host_busy
);
    // Choose the winning source
    always_comb begin
        wr_en     = core_we | host_we;
        wr_addr   = core_we ? core_waddr : host_waddr;
        wr_data   = core_we ? core_wdata : host_wdata;
        host_busy = core_we & host_we;
    end
endmodule

// File: rtl/opstore8.sv
// Replicated eight-read operand store.
// The winning write is broadcast to LANES identical banks, and each lane reads its own bank.
// Assumes that the packed lane order is k-th slice = lane k.
module opstore8
    import opstore_pkg::*;
#(
    parameter int LANES  = OS_LANES,
    parameter int ADDR_W = OS_ADDR_W,
    parameter int DATA_W = OS_DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    core_we,
    input  logic [ADDR_W-1:0]       core_waddr,
    input  logic [DATA_W-1:0]       core_wdata,
    input  logic                    host_we,
    input  logic [ADDR_W-1:0]       host_waddr,
    input  logic [DATA_W-1:0]       host_wdata,
    output logic                    host_busy,
    input  logic [LANES*ADDR_W-1:0] rd_addr,
    output logic [LANES*DATA_W-1:0] rd_data
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    opstore_wsel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wsel (
        .core_we    (core_we),
        .core_waddr (core_waddr),
        .core_wdata (core_wdata),
        .host_we    (host_we),
        .host_waddr (host_waddr),
        .host_wdata (host_wdata),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .host_busy  (host_busy)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_bank
        opstore_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (rd_addr[k*ADDR_W +: ADDR_W]),
            .rdata (rd_data[k*DATA_W +: DATA_W])
        );
    end
endmodule

// File: rtl/opstore8_chk.sv
// Checker for opstore8, attached with bind. It watches only the ports.
module opstore8_chk #(
    parameter int LANES  = 8,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    core_we,
    input logic                    host_we,
    input logic                    host_busy,
    input logic [LANES*ADDR_W-1:0] rd_addr,
    input logic [LANES*DATA_W-1:0] rd_data
);
    logic same_addr;
    logic same_data;

    // Detect all lanes addressing one entry, and all lanes returning one word
    always_comb begin
        same_addr = 1'b1;
        same_data = 1'b1;
        for (int k = 1; k < LANES; k++) begin
            if (rd_addr[k*ADDR_W +: ADDR_W] != rd_addr[0 +: ADDR_W]) same_addr = 1'b0;
            if (rd_data[k*DATA_W +: DATA_W] != rd_data[0 +: DATA_W]) same_data = 1'b0;
        end
    end

    AST_BUSY_NEEDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |-> core_we); // R4
    AST_BUSY_NEEDS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |-> host_we); // R4
    AST_LANES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        same_addr |=> same_data); // R2
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0)); // R7
endmodule

bind opstore8 opstore8_chk #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_we   (core_we),
    .host_we   (host_we),
    .host_busy (host_busy),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/tb_opstore8.sv
module tb_opstore8;
    localparam int L  = 8;
    localparam int AW = 9;
    localparam int DW = 32;
    localparam int D  = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              core_we = 1'b0, host_we = 1'b0;
    logic [AW-1:0]     core_waddr = '0, host_waddr = '0;
    logic [DW-1:0]     core_wdata = '0, host_wdata = '0;
    logic              host_busy;
    logic [L*AW-1:0]   rd_addr = '0;
    logic [L*DW-1:0]   rd_data;

    logic [DW-1:0]     model [D];
    logic [AW-1:0]     ra [L];
    int                n_chk = 0;
    int                n_bad = 0;

    always #2 clk = ~clk;

    opstore8 dut (
        .clk(clk), .rst_n(rst_n),
        .core_we(core_we), .core_waddr(core_waddr), .core_wdata(core_wdata),
        .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_busy(host_busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Read-first expectation: the model's value before this cycle's write
    function automatic logic [DW-1:0] expect_word(input logic [AW-1:0] a);
        return model[a];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, then compare each lane when requested
    task automatic step(input logic cw, input logic [AW-1:0] ca, input logic [DW-1:0] cd,
                        input logic hw, input logic [AW-1:0] ha, input logic [DW-1:0] hd,
                        input bit do_chk, input string req);
        logic [DW-1:0] exp [L];
        core_we = cw; core_waddr = ca; core_wdata = cd;
        host_we = hw; host_waddr = ha; host_wdata = hd;
        for (int k = 0; k < L; k++) begin
            rd_addr[k*AW +: AW] = ra[k];
            exp[k] = expect_word(ra[k]);
        end
        #1;
        check("R4 busy", {31'd0, host_busy}, {31'd0, cw & hw});
        if (cw) model[ca] = cd;
        else if (hw) model[ha] = hd;
        @(posedge clk); #1;
        if (do_chk) begin
            for (int k = 0; k < L; k++) check(req, rd_data[k*DW +: DW], exp[k]);
        end
    endtask

    task automatic all_lanes(input logic [AW-1:0] a);
        for (int k = 0; k < L; k++) ra[k] = a;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < L; k++) ra[k] = AW'(k);
        for (int k = 0; k < L; k++) rd_addr[k*AW +: AW] = ra[k];
        repeat (3) @(posedge clk);
        #1;
        // R7: outputs zero while in reset
        check("R7 reset", rd_data[0 +: DW] | rd_data[7*DW +: DW], '0);
        rst_n = 1'b1;

        // Fill every entry through the core port, lanes on distinct addresses
        for (int a = 0; a < D; a++) step(1'b1, AW'(a), $urandom, 1'b0, '0, '0, 1'b0, "fill");

        // R2, R8: write then read the same entry on all lanes next cycle
        all_lanes(9'd100);
        step(1'b1, 9'd100, 32'hCAFE_0001, 1'b0, '0, '0, 1'b0, "R6");
        step(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, "R8 R2 after write");

        // R6: read and write the same entry in one cycle gives old word
        all_lanes(9'd511);
        step(1'b1, 9'd511, 32'h1234_5678, 1'b0, '0, '0, 1'b1, "R6 read-first");
        step(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, "R6 new word next");

        // R3, R4: collision, core wins, host target untouched
        all_lanes(9'd7);
        step(1'b1, 9'd5, 32'hAAAA_5555, 1'b1, 9'd7, 32'hDEAD_BEEF, 1'b0, "R3");
        step(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, "R3 host target kept");
        all_lanes(9'd5);
        step(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, "R3 core stored");
        // R5: host retries with core idle
        all_lanes(9'd7);
        step(1'b0, '0, '0, 1'b1, 9'd7, 32'hDEAD_BEEF, 1'b0, "R5");
        step(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, "R5 host stored");

        // R1: random independent lanes with mixed write sources
        for (int i = 0; i < 3000; i++) begin
            for (int k = 0; k < L; k++) ra[k] = AW'($urandom);
            if (i % 16 == 0) all_lanes(AW'($urandom));
            step(($urandom % 3) == 0, AW'($urandom), $urandom,
                 ($urandom % 3) == 0, AW'($urandom), $urandom, 1'b1, "R1 random");
        end

        // R2: sweep every entry on all lanes
        for (int a = 0; a < D; a++) begin
            all_lanes(AW'(a));
            step(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, "R2 sweep");
        end

        // R7: reset mid-run clears the outputs
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R7 reset mid-run", rd_data[3*DW +: DW], '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule